// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register bus. A 16-bit down counter is stepped by a tick enable. That enable is made in two stages: first a programmable 8-bit prescaler that divides by P+1, then a fixed divider that the software selects as 16, 32, 64 or 128. When the counter has run out, the block can raise a sticky interrupt request, a reset request, or both. It then reloads the counter from a data register and keeps counting.

Software arms the block in four steps: write the reload value, set the divider, prescaler and enable bits in the control word, and write the count register. To keep the watchdog alive, software rewrites the count register before the timeout elapses. A debug-acknowledge input from the processor silences both requests while the control word's debug-mask bit is set. The bus has no stall cycle. A write takes effect at the clock edge where `bus_req` and `bus_wr` are high. Read data is combinational in the same cycle. The bus has no back-pressure.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0 (counting, interrupt and reset disabled), the data and count registers read 0x8000, and `irq` and `rst_req` are low.
- R2: Byte offsets are control 0x0, reload data 0x4, live count 0x8 and interrupt clear 0xC. In the control word, bit 0 enables reset, bit 2 enables the interrupt, bits 4:3 select the divider, bit 5 enables counting, bits 15:8 hold the prescale value P and bit 16 is the debug mask. All other control bits read as 0, so writing all ones reads back 0x0001FF3D. Reading the count register returns the live counter.
- R3: While counting is enabled, the counter steps once every (P+1)·(16·2^S) cycles, where S is the value of bits 4:3.
- R4: The counter expires on a step taken while it holds 0. The first expiry comes (C+1)·(P+1)·16·2^S cycles after the count register is written with C. On expiry the counter reloads from the data register and keeps counting.
- R5: On expiry with the interrupt enabled, a pending flag is set that drives `irq`. The flag stays set until any write to offset 0xC clears it. An expiry in the same cycle wins over the clear. Reads of 0xC return 0.
- R6: On expiry with reset enabled, `rst_req` goes high and stays high until `rst_n` is asserted. With the interrupt disabled, the same expiry leaves `irq` low.
- R7: While the debug mask bit and `dbg_ack` are both high, `irq` and `rst_req` are held low. A pending interrupt shows again once `dbg_ack` falls. With the mask bit clear, `dbg_ack` has no effect.
- R8: A write to the count register loads the written value and restarts both division stages. A write issued at any phase therefore starts a full timeout, and regular rewrites prevent expiry.
- R9: With the enable bit clear, the counter holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| dbg_ack | input | 1 | Processor is halted in debug |
| irq | output | 1 | Interrupt request (level) |
| rst_req | output | 1 | Reset request (level, sticky) |

## Verification
The assertions assume that only one bus access happens per cycle and that `dbg_ack` is a clean level sampled on `clk`. They also assume the bus is idle while `rst_n` is low, because the reload and freeze properties compare the counter against the previous cycle's write. The stimulus drives every bus access and every change of `dbg_ack` on the falling edge. It holds `bus_req` low during and right after each reset pulse. It clears the pending interrupt before each case so that every expiry it measures starts from a known state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // field layout of the control word (software-visible, fixed)
  localparam int BIT_RST  = 0;
  localparam int BIT_IRQ  = 2;
  localparam int SEL_LO   = 3;
  localparam int BIT_RUN  = 5;
  localparam int PRE_LO   = 8;
  localparam int BIT_DBG  = 16;
  localparam int PRE_BITS = 8;
  localparam int SEL_BITS = 2;

  // byte offsets
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_DATA = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;
  localparam logic [3:0] OFS_ICLR = 4'hC;

  typedef struct packed {
    logic                dbg_mask;
    logic [PRE_BITS-1:0] presc;
    logic                run;
    logic [SEL_BITS-1:0] div_sel;
    logic                irq_en;
    logic                rst_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.rst_en   = w[BIT_RST];
    c.irq_en   = w[BIT_IRQ];
    c.div_sel  = w[SEL_LO +: SEL_BITS];
    c.run      = w[BIT_RUN];
    c.presc    = w[PRE_LO +: PRE_BITS];
    c.dbg_mask = w[BIT_DBG];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_RST]              = c.rst_en;
    w[BIT_IRQ]              = c.irq_en;
    w[SEL_LO +: SEL_BITS]   = c.div_sel;
    w[BIT_RUN]              = c.run;
    w[PRE_LO +: PRE_BITS]   = c.presc;
    w[BIT_DBG]              = c.dbg_mask;
    return w;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  data_q,
  output logic              cnt_wr,
  output logic              iclr_wr,
  output logic [31:0]       rdata
);
  localparam int PAD_W = 32 - CNT_W;

  logic hit_ctrl, hit_data, hit_cnt, hit_iclr;
  logic ctrl_wr, data_wr;
  ctrl_t ctrl_nxt;
  logic unused_wbits;

  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_data = (addr == ADDR_W'(OFS_DATA));
  assign hit_cnt  = (addr == ADDR_W'(OFS_CNT));
  assign hit_iclr = (addr == ADDR_W'(OFS_ICLR));

  assign ctrl_wr = req && wr && hit_ctrl;
  assign data_wr = req && wr && hit_data;
  assign cnt_wr  = req && wr && hit_cnt;
  assign iclr_wr = req && wr && hit_iclr;

  assign ctrl_nxt = ctrl_from_word(wdata);
  assign unused_wbits = ^{wdata[31:17], wdata[7:6], wdata[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      data_q <= RESET_VAL;
    end else begin
      if (ctrl_wr) ctrl   <= ctrl_nxt;
      if (data_wr) data_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (req && !wr) begin
      if (hit_ctrl)      rdata = ctrl_to_word(ctrl);
      else if (hit_data) rdata = {{PAD_W{1'b0}}, data_q};
      else if (hit_cnt)  rdata = {{PAD_W{1'b0}}, live_cnt};
      else               rdata = '0;  // clear register and holes read 0
    end
  end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRESC_W = 8,
  parameter int SEL_W = 2,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SEL_W-1:0]   div_sel,
  output logic               tick
);
  localparam int SEL_N = 1 << SEL_W;
  localparam int DIV_W = DIV_BASE_LOG2 + SEL_N - 1;

  logic [DIV_W-1:0]   div_lim [SEL_N];
  logic [PRESC_W-1:0] pre_q;
  logic [DIV_W-1:0]   div_q;
  logic               pre_hit, div_hit;

  // terminal count of the divider stage for each selection: 2^(base+g) - 1
  for (genvar g = 0; g < SEL_N; g++) begin : g_lim
    assign div_lim[g] = {DIV_W{1'b1}} >> (SEL_N - 1 - g);
  end

  assign pre_hit = (pre_q == presc);
  assign div_hit = (div_q == div_lim[div_sel]);
  assign tick    = run && pre_hit && div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_hit) begin
      pre_q <= '0;
      div_q <= div_hit ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             iclr,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             irq_pend,
  output logic             rst_hit
);
  assign expire = tick && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RESET_VAL;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
      rst_hit  <= 1'b0;
    end else begin
      if (expire && irq_en) irq_pend <= 1'b1;
      else if (iclr)        irq_pend <= 1'b0;
      if (expire && rst_en) rst_hit  <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W = 16,
  parameter int DIV_BASE_LOG2 = 4,
  parameter logic [CNT_W-1:0] RESET_VAL = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_ack,
  output logic              irq,
  output logic              rst_req
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] data_q, cnt, wr_val;
  logic             cnt_wr, iclr_wr, tick, expire, irq_pend, rst_hit;
  logic             run, dbg_mask, quiet;

  assign run      = ctrl_q.run;
  assign dbg_mask = ctrl_q.dbg_mask;
  assign wr_val   = bus_wdata[CNT_W-1:0];

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .live_cnt(cnt), .ctrl(ctrl_q), .data_q(data_q),
    .cnt_wr(cnt_wr), .iclr_wr(iclr_wr), .rdata(bus_rdata)
  );

  wdog_tick #(.PRESC_W(PRE_BITS), .SEL_W(SEL_BITS), .DIV_BASE_LOG2(DIV_BASE_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr),
    .presc(ctrl_q.presc), .div_sel(ctrl_q.div_sel), .tick(tick)
  );

  wdog_count #(.CNT_W(CNT_W), .RESET_VAL(RESET_VAL)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr), .load_val(wr_val),
    .reload_val(data_q), .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en),
    .iclr(iclr_wr), .cnt(cnt), .expire(expire), .irq_pend(irq_pend),
    .rst_hit(rst_hit)
  );

  assign quiet   = dbg_mask && dbg_ack;
  assign irq     = irq_pend && !quiet;
  assign rst_req = rst_hit && !quiet;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wr_val,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] data_q,
  input logic             expire,
  input logic             iclr_wr,
  input logic             irq_pend,
  input logic             rst_hit,
  input logic             dbg_mask,
  input logic             dbg_ack,
  input logic             irq,
  input logic             rst_req
);
  // R9
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R8
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wr_val)));

  // R4
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(data_q)));

  // R5
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr_wr && !expire) |=> !irq_pend);

  // R6
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> rst_hit);

  // R7
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mask && dbg_ack) |-> (!irq && !rst_req));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr), .wr_val(wr_val),
  .cnt(cnt), .data_q(data_q), .expire(expire), .iclr_wr(iclr_wr),
  .irq_pend(irq_pend), .rst_hit(rst_hit), .dbg_mask(dbg_mask),
  .dbg_ack(dbg_ack), .irq(irq), .rst_req(rst_req)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_ack = 1'b0;
  logic        irq, rst_req;

  int checks = 0;
  int fails = 0;
  int n;
  logic [31:0] rd, rd2;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_ack(dbg_ack), .irq(irq), .rst_req(rst_req)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_CNT = 4'h8, A_ICLR = 4'hC;

  // {prescale, divider select, start count, expected cycles to expiry}
  localparam int NV = 4;
  localparam logic [41:0] VEC [NV] = '{
    {8'd0, 2'd0, 16'd3, 16'd64},
    {8'd2, 2'd1, 16'd2, 16'd288},
    {8'd1, 2'd3, 16'd1, 16'd512},
    {8'd0, 2'd2, 16'd0, 16'd64}
  };

  function automatic logic [31:0] cfg(input logic [7:0] p, input logic [1:0] s,
                                      input logic run, input logic ie,
                                      input logic re, input logic dm);
    return {15'd0, dm, p, 2'b00, run, s, ie, 1'b0, re};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wait_sig(input logic use_rst, input int start, output int cnt_o);
    cnt_o = start;
    while (((use_rst ? rst_req : irq) == 1'b0) && cnt_o < 5000) begin
      @(negedge clk);
      cnt_o++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    rdreg(A_CTRL, rd); chk("R1 ctrl", rd, 32'h0);
    rdreg(A_DATA, rd); chk("R1 data", rd, 32'h8000);
    rdreg(A_CNT, rd);  chk("R1 count", rd, 32'h8000);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    // R2 control readback and R5 clear register reads zero
    wr(A_CTRL, 32'hFFFF_FFFF);
    rdreg(A_CTRL, rd); chk("R2 ctrl readback", rd, 32'h0001_FF3D);
    wr(A_CTRL, 32'h0);
    rdreg(A_ICLR, rd); chk("R5 clear reads zero", rd, 32'h0);

    // R3 R4: vector table, first expiry and the period after reload
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  p;
      logic [1:0]  s;
      logic [15:0] c, e;
      {p, s, c, e} = VEC[i];
      wr(A_CTRL, 32'h0);
      wr(A_ICLR, 32'h0);
      wr(A_DATA, {16'd0, c});
      wr(A_CTRL, cfg(p, s, 1'b1, 1'b1, 1'b0, 1'b0));
      wr(A_CNT, {16'd0, c});
      wait_sig(1'b0, 0, n);
      chk("R3 R4 first expiry", n, {16'd0, e});
      wr(A_ICLR, 32'h1);
      wait_sig(1'b0, 1, n);
      chk("R4 reload period", n, {16'd0, e});
    end

    // R5 sticky pending and clear; R9 freeze
    wr(A_CTRL, 32'h0);
    wr(A_ICLR, 32'h0);
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(A_CNT, 32'd0);
    wait_sig(1'b0, 0, n);
    chk("R5 expiry at 16", n, 32'd16);
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    rdreg(A_CNT, rd);
    repeat (50) @(negedge clk);
    chk("R5 irq sticky", {31'd0, irq}, 32'd1);
    rdreg(A_CNT, rd2);
    chk("R9 count frozen", rd2, rd);
    wr(A_ICLR, 32'hDEAD);
    chk("R5 irq cleared", {31'd0, irq}, 32'd0);

    // R2 live count read
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    wr(A_CNT, 32'd10);
    repeat (50) @(negedge clk);
    rdreg(A_CNT, rd);
    chk("R2 live count", rd, 32'd7);

    // R8 refresh keeps it alive, restart from arbitrary phase
    wr(A_CTRL, 32'h0);
    wr(A_ICLR, 32'h0);
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(A_CNT, 32'd2);
    for (int k = 0; k < 5; k++) begin
      repeat (29) @(negedge clk);
      chk("R8 no expiry while refreshed", {31'd0, irq}, 32'd0);
      wr(A_CNT, 32'd2);
    end
    wait_sig(1'b0, 0, n);
    chk("R8 timeout after last refresh", n, 32'd48);

    // R7 debug masking
    wr(A_CTRL, 32'h0);
    wr(A_ICLR, 32'h0);
    dbg_ack = 1'b1;
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1));
    wr(A_CNT, 32'd0);
    repeat (30) @(negedge clk);
    chk("R7 irq masked in debug", {31'd0, irq}, 32'd0);
    dbg_ack = 1'b0;
    #1 chk("R7 irq visible after debug", {31'd0, irq}, 32'd1);
    @(negedge clk);
    dbg_ack = 1'b1;
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0));
    chk("R7 no mask bit, dbg_ack ignored", {31'd0, irq}, 32'd1);
    dbg_ack = 1'b0;

    // R6 reset request
    wr(A_ICLR, 32'h0);
    wr(A_CTRL, cfg(8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0));
    wr(A_CNT, 32'd0);
    wait_sig(1'b1, 0, n);
    chk("R6 reset request at 16", n, 32'd16);
    chk("R6 irq stays low", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h0);
    repeat (20) @(negedge clk);
    chk("R6 reset request sticky", {31'd0, rst_req}, 32'd1);
    do_reset();
    chk("R6 cleared by rst_n", {31'd0, rst_req}, 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule